// File: doc/BRIEF.md
# Stepper Microstep Translator

This block turns a step/direction command stream into signed current setpoints for the two windings of a bipolar stepper motor. A 6-bit electrical position covers one full electrical cycle in 64 positions of 5.625 degrees each. Every rising edge on the step input moves that position by a stride that the resolution mode sets. The position is then mapped through one shared quarter-wave magnitude table into a sign and a magnitude for each winding. A downstream current DAC and chopper take these values. The magnitude code is the commanded current in hundredths of a percent of peak trip current.

The two windings follow the same table with a 90 degree offset. Winding A carries |sin| of the electrical angle and winding B carries |cos|. Every resolution starts from the 45 degree home point and strides across the same 64-position grid. Each coarse resolution therefore visits a subset of the fine angles and never an angle of its own. The step, direction and mode inputs pass through a synchronizer. Direction and mode are taken only at the detected step edge.

Top module: `microstep_translator`

## Requirements
- R1: A synchronous active-high reset puts the position at home, index 8 (45 degrees). Both outputs then read magnitude 7071 with sign 0 (positive), whatever the earlier position or mode.
- R2: The mode code mode_in[2:0] selects the resolution: 3'b000 full, 3'b100 half, 3'b010 quarter, 3'b110 eighth, 3'b111 sixteenth. Any other code acts as sixteenth.
- R3: Each rising edge of step_in moves the position by exactly one stride: 16 (full), 8 (half), 4 (quarter), 2 (eighth) or 1 (sixteenth). Holding step_in high gives only one move.
- R4: dir_in = 1 increases the electrical angle and dir_in = 0 decreases it. The index wraps modulo 64 in both directions.
- R5: For index p, angle = p*5.625 degrees. mag_a = round(10000*|sin|) and mag_b = round(10000*|cos|). The quarter-wave values for 0 to 15 sixteenth steps from a peak are 10000, 9952, 9808, 9569, 9239, 8819, 8315, 7730, 7071, 6344, 5556, 4714, 3827, 2903, 1951 and 980. A zero crossing gives 0.
- R6: sign_a is 1 when sin is negative and sign_b is 1 when cos is negative. A winding with magnitude 0 reports sign 0.
- R7: In full-step mode, started from a position on its grid, both magnitudes stay 7071 and only the signs change.
- R8: Each mode has a grid of valid positions. For full step the grid is 8 + 16k. For the other modes it is the multiples of the stride. A step taken from a position off the current grid lands on the nearest grid point in the direction of travel, and a step from a grid point moves one full stride.
- R9: Changes of mode_in or dir_in with no step edge leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset to home |
| step_in | input | 1 | Step request, asynchronous; rising edge moves the position |
| dir_in | input | 1 | Direction, 1 = increasing angle |
| mode_in | input | 3 | Resolution select code |
| sign_a | output | 1 | Winding A sign, 1 = negative |
| mag_a | output | 14 | Winding A magnitude, 0.01 % units |
| sign_b | output | 1 | Winding B sign, 1 = negative |
| mag_b | output | 14 | Winding B magnitude, 0.01 % units |

## Verification
A long sixteenth-step sweep passes the 63-to-0 wrap and both zero crossings of each winding. A design with a reversed quadrant mapping or a wrong sign at zero would put out a wrong value or a "negative zero" there. Mode switches taken from positions off the grid check the rounding. A design that always adds the full stride would settle on angles the coarse mode never uses, for example 27 instead of 24 in full step. A step input held high, and mode or direction changes with no step, must not move the position. A design that triggers on level, or that does not latch the inputs at the edge, would drift here.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

    localparam int IDX_W       = 6;
    localparam int QTR_W       = 4;
    localparam int QUARTER_POS = 1 << QTR_W;
    localparam int MAG_W       = 14;
    localparam int NUM_COILS   = 2;
    localparam int MODE_W      = 3;
    localparam logic [IDX_W-1:0] HOME_IDX = IDX_W'(QUARTER_POS / 2);
    localparam logic [MAG_W-1:0] MAG_DIAG = MAG_W'(7071);

    typedef enum logic [2:0] {
        RES_FULL,
        RES_HALF,
        RES_QUARTER,
        RES_EIGHTH,
        RES_SIXTEENTH
    } res_e;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } coil_t;

    typedef coil_t [NUM_COILS-1:0] setpoint_t;

    function automatic res_e decode_mode(input logic [MODE_W-1:0] code);
        case (code)
            3'b000:  return RES_FULL;
            3'b100:  return RES_HALF;
            3'b010:  return RES_QUARTER;
            3'b110:  return RES_EIGHTH;
            default: return RES_SIXTEENTH;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] stride_of(input res_e r);
        case (r)
            RES_FULL:    return IDX_W'(16);
            RES_HALF:    return IDX_W'(8);
            RES_QUARTER: return IDX_W'(4);
            RES_EIGHTH:  return IDX_W'(2);
            default:     return IDX_W'(1);
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] grid_base(input res_e r);
        return (r == RES_FULL) ? HOME_IDX : '0;
    endfunction

    // quarter-wave table: cosine of k sixteenth steps, 0.01 % units
    function automatic logic [MAG_W-1:0] qwave(input logic [QTR_W:0] k);
        case (k)
            5'd0:    return MAG_W'(10000);
            5'd1:    return MAG_W'(9952);
            5'd2:    return MAG_W'(9808);
            5'd3:    return MAG_W'(9569);
            5'd4:    return MAG_W'(9239);
            5'd5:    return MAG_W'(8819);
            5'd6:    return MAG_W'(8315);
            5'd7:    return MAG_W'(7730);
            5'd8:    return MAG_W'(7071);
            5'd9:    return MAG_W'(6344);
            5'd10:   return MAG_W'(5556);
            5'd11:   return MAG_W'(4714);
            5'd12:   return MAG_W'(3827);
            5'd13:   return MAG_W'(2903);
            5'd14:   return MAG_W'(1951);
            5'd15:   return MAG_W'(980);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/step_input_sync.sv
module step_input_sync
    import stepper_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_raw,
    input  logic              dir_raw,
    input  logic [MODE_W-1:0] mode_raw,
    output logic              step_evt,
    output logic              dir_fwd,
    output res_e              res_sel
);

    localparam int BUS_W = MODE_W + 2;

    logic [BUS_W-1:0] chain [SYNC_STAGES];
    logic             step_prev;
    logic [BUS_W-1:0] synced;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= {step_raw, dir_raw, mode_raw};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign synced = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) step_prev <= 1'b0;
        else     step_prev <= synced[BUS_W-1];
    end

    assign step_evt = synced[BUS_W-1] & ~step_prev;
    assign dir_fwd  = synced[BUS_W-2];
    assign res_sel  = decode_mode(synced[MODE_W-1:0]);

    // R3: an edge yields a single-cycle event
    a_r3_single_event: assert property (@(posedge clk) disable iff (rst)
        step_evt |=> !step_evt);

endmodule

// File: rtl/step_index_seq.sv
module step_index_seq
    import stepper_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_evt,
    input  logic             dir_fwd,
    input  res_e             res_sel,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] stride;
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] rem;
    logic [IDX_W-1:0] idx_nxt;

    always_comb begin
        stride = stride_of(res_sel);
        base   = grid_base(res_sel);
        rem    = (idx - base) & (stride - IDX_W'(1));
        if (dir_fwd)
            idx_nxt = idx + ((rem == '0) ? stride : (stride - rem));
        else
            idx_nxt = idx - ((rem == '0) ? stride : rem);
    end

    always_ff @(posedge clk) begin
        if (rst)           idx <= HOME_IDX;
        else if (step_evt) idx <= idx_nxt;
    end

    // R1: reset lands on home
    a_r1_home_after_reset: assert property (@(posedge clk)
        rst |=> idx == HOME_IDX);

    // R9: no step, no motion
    a_r9_hold_without_step: assert property (@(posedge clk) disable iff (rst)
        !step_evt |=> idx == $past(idx));

    // R8: every step ends on the grid of the mode it was taken in
    a_r8_lands_on_grid: assert property (@(posedge clk) disable iff (rst)
        step_evt |=> (((idx - $past(base)) & ($past(stride) - IDX_W'(1))) == '0));

    // R4: a step always moves the position
    a_r4_step_moves: assert property (@(posedge clk) disable iff (rst)
        step_evt |=> idx != $past(idx));

endmodule

// File: rtl/phase_current_map.sv
module phase_current_map
    import stepper_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    output setpoint_t        sp
);

    setpoint_t sp_nxt;
    setpoint_t sp_home;

    generate
        for (genvar c = 0; c < NUM_COILS; c++) begin : g_coil
            // winding c is the sine wave advanced by c quarter cycles
            localparam logic [IDX_W-1:0] SHIFT = IDX_W'(c * QUARTER_POS);
            logic [IDX_W-1:0] pos;
            logic [1:0]       quad;
            logic [QTR_W:0]   k_rise;
            logic [QTR_W:0]   k_fall;
            logic [MAG_W-1:0] mag;

            always_comb begin
                pos    = idx + SHIFT;
                quad   = pos[IDX_W-1 -: 2];
                k_rise = {1'b0, pos[QTR_W-1:0]};
                k_fall = (QTR_W+1)'(QUARTER_POS) - k_rise;
                mag    = quad[0] ? qwave(k_rise) : qwave(k_fall);
                sp_nxt[c].mag = mag;
                sp_nxt[c].neg = quad[1] && (mag != '0);
                sp_home[c].mag = MAG_DIAG;
                sp_home[c].neg = 1'b0;
            end

            // R6: zero current is never reported negative
            a_r6_zero_positive: assert property (@(posedge clk) disable iff (rst)
                (sp[c].mag == '0) |-> !sp[c].neg);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sp <= sp_home;
        else     sp <= sp_nxt;
    end

    // R5: quadrature windings, at least one is at or above the diagonal level
    a_r5_one_winding_strong: assert property (@(posedge clk) disable iff (rst)
        (sp[0].mag >= MAG_DIAG) || (sp[1].mag >= MAG_DIAG));

endmodule

// File: rtl/microstep_translator.sv
module microstep_translator
    import stepper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_in,
    input  logic              dir_in,
    input  logic [MODE_W-1:0] mode_in,
    output logic              sign_a,
    output logic [MAG_W-1:0]  mag_a,
    output logic              sign_b,
    output logic [MAG_W-1:0]  mag_b
);

    logic             step_evt;
    logic             dir_fwd;
    res_e             res_sel;
    logic [IDX_W-1:0] idx;
    setpoint_t        sp;

    step_input_sync #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .step_raw (step_in),
        .dir_raw  (dir_in),
        .mode_raw (mode_in),
        .step_evt (step_evt),
        .dir_fwd  (dir_fwd),
        .res_sel  (res_sel)
    );

    step_index_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .step_evt (step_evt),
        .dir_fwd  (dir_fwd),
        .res_sel  (res_sel),
        .idx      (idx)
    );

    phase_current_map u_map (
        .clk (clk),
        .rst (rst),
        .idx (idx),
        .sp  (sp)
    );

    assign sign_a = sp[0].neg;
    assign mag_a  = sp[0].mag;
    assign sign_b = sp[1].neg;
    assign mag_b  = sp[1].mag;

    // R7: a full-step move from a full-step grid point keeps the diagonal level
    a_r7_full_step_level: assert property (@(posedge clk) disable iff (rst)
        (step_evt && res_sel == RES_FULL && idx[QTR_W-1:0] == HOME_IDX[QTR_W-1:0])
        |=> ##1 (mag_a == MAG_DIAG && mag_b == MAG_DIAG));

endmodule

// File: tb/test_microstep_translator.sv
`timescale 1ns/1ps
module test_microstep_translator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_in = 1'b0;
    logic        dir_in = 1'b1;
    logic [2:0]  mode_in = 3'b111;
    logic        sign_a, sign_b;
    logic [13:0] mag_a, mag_b;

    int checks = 0;
    int errors = 0;
    int exp_idx = 8;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    microstep_translator i_microstep_translator (
        .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in),
        .mode_in(mode_in), .sign_a(sign_a), .mag_a(mag_a),
        .sign_b(sign_b), .mag_b(mag_b)
    );

    function automatic int stride_for(input logic [2:0] m);
        case (m)
            3'b000: return 16;
            3'b100: return 8;
            3'b010: return 4;
            3'b110: return 2;
            default: return 1;
        endcase
    endfunction

    // R8 model: walk one position at a time until a grid point is reached
    function automatic int model_next(input int p, input logic [2:0] m, input bit fwd);
        int s = stride_for(m);
        int b = (s == 16) ? 8 : 0;
        int q = p;
        for (int n = 0; n < 64; n++) begin
            q = fwd ? (q + 1) % 64 : (q + 63) % 64;
            if (((q - b + 64) % s) == 0) return q;
        end
        return q;
    endfunction

    function automatic int wave_mag(input int p, input bit use_cos, output bit neg);
        real th = 2.0 * 3.14159265358979 * p / 64.0;
        real v = use_cos ? $cos(th) : $sin(th);
        int m = $rtoi(((v < 0.0) ? -v : v) * 10000.0 + 0.5);
        neg = (v < 0.0) && (m != 0);
        return m;
    endfunction

    task automatic check_out(input string tag);
        bit na, nb;
        int ma = wave_mag(exp_idx, 1'b0, na);
        int mb = wave_mag(exp_idx, 1'b1, nb);
        checks++;
        if (mag_a !== 14'(ma) || sign_a !== na || mag_b !== 14'(mb) || sign_b !== nb) begin
            errors++;
            $display("FAIL %s idx=%0d actual a=%0b/%0d b=%0b/%0d expected a=%0b/%0d b=%0b/%0d",
                     tag, exp_idx, sign_a, mag_a, sign_b, mag_b, na, ma, nb, mb);
        end
    endtask

    task automatic set_inputs(input logic [2:0] m, input bit d);
        @(negedge clk);
        mode_in = m;
        dir_in  = d;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_step();
        @(negedge clk);
        step_in = 1'b1;
        repeat (4) @(negedge clk);
        step_in = 1'b0;
        repeat (4) @(negedge clk);
        exp_idx = model_next(exp_idx, mode_in, dir_in);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_idx = 8;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        check_out("R1 reset home");
    endtask

    task automatic t_fine_sweep();
        set_inputs(3'b111, 1'b1);
        for (int i = 0; i < 66; i++) begin
            pulse_step();
            check_out("R3 R4 R5 R6 sixteenth forward sweep with wrap");
        end
        set_inputs(3'b111, 1'b0);
        for (int i = 0; i < 20; i++) begin
            pulse_step();
            check_out("R4 R5 R6 sixteenth backward with wrap");
        end
    endtask

    task automatic t_mode_strides();
        do_reset();
        set_inputs(3'b110, 1'b1);
        for (int i = 0; i < 5; i++) begin pulse_step(); check_out("R2 R3 eighth stride"); end
        set_inputs(3'b010, 1'b0);
        for (int i = 0; i < 5; i++) begin pulse_step(); check_out("R2 R3 quarter stride"); end
        set_inputs(3'b100, 1'b1);
        for (int i = 0; i < 9; i++) begin pulse_step(); check_out("R2 R3 half stride"); end
    endtask

    task automatic t_full_step();
        do_reset();
        set_inputs(3'b000, 1'b1);
        for (int i = 0; i < 5; i++) begin
            pulse_step();
            check_out("R7 full step sequence");
            checks++;
            if (mag_a !== 14'd7071 || mag_b !== 14'd7071) begin
                errors++;
                $display("FAIL R7 full step level actual %0d/%0d expected 7071/7071", mag_a, mag_b);
            end
        end
    endtask

    task automatic t_regrid();
        do_reset();
        set_inputs(3'b111, 1'b1);
        repeat (3) pulse_step();
        check_out("R8 fine position 11");
        set_inputs(3'b000, 1'b1);
        pulse_step();
        checks++;
        if (exp_idx != 24) begin errors++; $display("FAIL R8 model actual %0d expected 24", exp_idx); end
        check_out("R8 full forward from 11 lands on 24");
        set_inputs(3'b111, 1'b1);
        repeat (3) pulse_step();
        set_inputs(3'b000, 1'b0);
        pulse_step();
        check_out("R8 full backward from 27 lands on 24");
        set_inputs(3'b111, 1'b0);
        repeat (15) pulse_step();
        set_inputs(3'b010, 1'b1);
        pulse_step();
        check_out("R8 quarter forward from 9 lands on 12");
        set_inputs(3'b100, 1'b0);
        pulse_step();
        check_out("R8 half backward from 12 lands on 8");
    endtask

    task automatic t_unused_codes();
        do_reset();
        set_inputs(3'b001, 1'b1); pulse_step(); check_out("R2 code 001 as sixteenth");
        set_inputs(3'b011, 1'b1); pulse_step(); check_out("R2 code 011 as sixteenth");
        set_inputs(3'b101, 1'b0); pulse_step(); check_out("R2 code 101 as sixteenth");
    endtask

    task automatic t_no_step_effect();
        do_reset();
        set_inputs(3'b111, 1'b1);
        repeat (5) pulse_step();
        set_inputs(3'b000, 1'b0);
        set_inputs(3'b100, 1'b1);
        repeat (10) @(negedge clk);
        check_out("R9 mode and dir changes without step");
        set_inputs(3'b111, 1'b1);
        @(negedge clk);
        step_in = 1'b1;
        repeat (30) @(negedge clk);
        exp_idx = model_next(exp_idx, 3'b111, 1'b1);
        check_out("R3 held step moves once");
        step_in = 1'b0;
        repeat (6) @(negedge clk);
        check_out("R3 release gives no move");
    endtask

    task automatic t_reset_midway();
        set_inputs(3'b110, 1'b0);
        repeat (7) pulse_step();
        check_out("R1 before mid reset");
        do_reset();
        check_out("R1 mid-run reset to home");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_fine_sweep();
        t_mode_strides();
        t_full_step();
        t_regrid();
        t_unused_codes();
        t_no_step_effect();
        t_reset_midway();
        finish_run();
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

endmodule